// File: doc/BRIEF.md
# Input Capture Timer

This block is a 16-bit up-counter with one input capture channel, two compare-match detectors, an overflow flag and an interrupt mask, all reached by a CPU over an 8-bit register bus. An external prescaler decides when the counter moves by driving `count_en`. When the selected event source shows the selected edge, the counter value at that moment is copied into the capture register and the capture flag is raised. The event source is either the capture pin or a comparator output, both arriving as asynchronous digital inputs.

The 16-bit registers (counter, capture, compare A, compare B) are reached one byte at a time. All of them share a single 8-bit holding register. Reading a low byte takes a snapshot of the matching high byte into the holding register, and writing a high byte parks it there until the low byte write commits both halves. Software therefore always sees a whole 16-bit value, whatever the counter does between the two byte accesses. A mode bit turns the capture register into the counter's wrap value, which gives a programmable period.

The interrupt request is one level output. It is high when at least one flag is set whose mask bit is set, and only while the global enable input is high.

Top module: `icu_timer`

## Requirements
- R1: After reset the counter, capture, compare A and compare B registers read 0x0000, the control (address 8), mask (address 9) and flag (address 10) registers read 0x00, and `irq` is low.
- R2: With top-from-capture mode off, the counter adds 1 at each rising clock edge where `count_en` is high and holds otherwise. From 0xFFFF it steps to 0x0000 and sets the overflow flag (flag bit 2).
- R3: With control bit 2 set (top-from-capture mode), the counter steps to 0x0000 from a value equal to the capture register and sets the overflow flag on that step. Capture events are ignored in this mode: the capture register keeps its value and flag bit 5 stays clear.
- R4: A qualifying edge on the selected source passes through a two-flop synchroniser. The capture register then holds the counter value from the third rising clock edge after the input changes, and the capture flag (flag bit 5) is set.
- R5: Control bit 0 picks the capture edge: 1 means rising, 0 means falling. An edge of the other polarity leaves the capture register unchanged.
- R6: Control bit 1 picks the event source: 0 means the capture pin, 1 means the comparator input. Edges on the source that is not selected leave the capture register unchanged.
- R7: A read of a low byte (address 0 counter, 2 capture, 4 compare A, 6 compare B) with `bus_rd` high returns that byte and loads the word's high byte into the one shared holding register. A read of any high byte (addresses 1, 3, 5, 7) returns the holding register, so later counter movement does not affect it.
- R8: A write to any high-byte address (1, 3, 5, 7) only loads the holding register. A later write to a low-byte address updates all 16 bits of that word at once, with the holding register as the high byte.
- R9: A counter step from a value equal to compare A sets flag bit 4, and a step from a value equal to compare B sets flag bit 3.
- R10: Writing the flag register (address 10) clears each flag whose bit in the written byte is 1 and leaves the flags whose bit is 0 unchanged. A flag that is set and cleared in the same cycle ends up set.
- R11: The mask register (address 9) has read/write enable bits 5 (capture), 4 (compare A), 3 (compare B) and 2 (overflow). Its other bits read 0. `irq` is high exactly when `global_ie` is 1 and some flag is set together with its mask bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| count_en | input | 1 | Counter step enable from the prescaler |
| global_ie | input | 1 | Global interrupt enable |
| cap_pin | input | 1 | Asynchronous capture pin |
| cmp_in | input | 1 | Asynchronous comparator output, alternative capture source |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (updates the holding register on low-byte reads) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, same cycle |
| irq | output | 1 | Interrupt request level |

## Verification
If the shared holding register loads at the wrong moment, the very next high-byte read returns a byte that does not match the low byte just read. A counter that is stepped in the middle of a split read therefore shows the fault within two bus cycles. A synchroniser that is one stage too short or too long moves the capture by one clock, and that is visible in a read issued right at the third edge after the input change. Faults in wrapping, flag priority or edge and source selection show up as a wrong captured word, or a wrong flag byte, on the first read after the stimulus.

// File: rtl/icu_pkg.sv
package icu_pkg;

  localparam int ADDR_W = 4;
  localparam int CTRL_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL = 4'd8;
  localparam logic [ADDR_W-1:0] A_MASK = 4'd9;
  localparam logic [ADDR_W-1:0] A_FLAG = 4'd10;

  localparam int FLG_CAP  = 5;
  localparam int FLG_CMPA = 4;
  localparam int FLG_CMPB = 3;
  localparam int FLG_OVF  = 2;

  // word selected by address bits [2:1] for the 16-bit register range
  typedef enum logic [1:0] {
    W_CNT  = 2'd0,
    W_CAP  = 2'd1,
    W_CMPA = 2'd2,
    W_CMPB = 2'd3
  } word_e;

  typedef struct packed {
    logic top_cap;   // bit 2: counter wraps at capture value
    logic src_cmp;   // bit 1: comparator input is the event source
    logic edge_rise; // bit 0: rising edge captures
  } ctrl_t;

endpackage

// File: rtl/icu_edge_sync.sv
module icu_edge_sync #(
  parameter int STAGES = 2,
  parameter int SRCS   = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [SRCS-1:0]         raw_i,
  input  logic [$clog2(SRCS)-1:0] sel_i,
  input  logic                    rise_i,
  output logic                    evt_o
);

  logic [SRCS-1:0] synced;
  logic            picked;
  logic            prev_q;

  for (genvar g = 0; g < SRCS; g++) begin : g_src
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb begin
      chain_d = {chain_q[STAGES-2:0], raw_i[g]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= chain_d;
    end

    assign synced[g] = chain_q[STAGES-1];
  end

  assign picked = synced[sel_i];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= picked;
  end

  always_comb begin
    if (rise_i) evt_o = picked & ~prev_q;
    else        evt_o = ~picked & prev_q;
  end

endmodule

// File: rtl/icu_counter.sv
module icu_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         count_en,
  input  logic         top_mode,
  input  logic [W-1:0] top_val,
  input  logic         wr_en,
  input  logic [W-1:0] wr_val,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);

  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         at_top;
  logic         cnt_en;

  always_comb begin
    at_top = top_mode ? (cnt_q == top_val) : (cnt_q == '1);
    wrap_o = count_en & ~wr_en & at_top;
    cnt_en = count_en | wr_en;
    if (wr_en)       cnt_d = wr_val;
    else if (at_top) cnt_d = '0;
    else             cnt_d = cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/icu_regif.sv
module icu_regif
  import icu_pkg::*;
#(
  parameter int BUS_W  = 8,
  parameter int N_CMP  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [BUS_W-1:0]      wdata,
  output logic [BUS_W-1:0]      rdata,
  input  logic                  count_en,
  input  logic                  global_ie,
  input  logic [2*BUS_W-1:0]    cnt_i,
  input  logic                  evt_i,
  input  logic                  wrap_i,
  output logic                  cnt_wr_o,
  output logic [2*BUS_W-1:0]    cnt_wr_val_o,
  output logic [2*BUS_W-1:0]    cap_o,
  output ctrl_t                 ctrl_o,
  output logic [BUS_W-1:0]      mask_o,
  output logic [BUS_W-1:0]      flags_o,
  output logic                  irq_o
);

  localparam int WW = 2 * BUS_W;
  localparam logic [BUS_W-1:0] FLG_VALID =
    BUS_W'((1 << FLG_CAP) | (1 << FLG_CMPA) | (1 << FLG_CMPB) | (1 << FLG_OVF));

  logic [BUS_W-1:0] temp_q, temp_d;
  logic             temp_en;
  logic [WW-1:0]    cap_q, cap_d;
  logic             cap_en;
  logic [WW-1:0]    cmp_q [N_CMP];
  logic [N_CMP-1:0] cmp_hit;
  ctrl_t            ctrl_q;
  logic             ctrl_en;
  logic [BUS_W-1:0] mask_q;
  logic             mask_en;
  logic [BUS_W-1:0] flags_q, flags_d, set_vec, clr_vec;
  logic             flags_en;

  logic             in_words;
  logic             hi_wr, lo_wr, lo_rd;
  word_e            wsel;
  logic [WW-1:0]    full_word;
  logic [WW-1:0]    cur_word;
  logic             cap_evt;

  // decode
  always_comb begin
    in_words  = (addr < A_CTRL);
    hi_wr     = wr_en & in_words & addr[0];
    lo_wr     = wr_en & in_words & ~addr[0];
    lo_rd     = rd_en & in_words & ~addr[0];
    wsel      = word_e'(addr[2:1]);
    full_word = {temp_q, wdata};
    case (wsel)
      W_CNT:   cur_word = cnt_i;
      W_CAP:   cur_word = cap_q;
      W_CMPA:  cur_word = cmp_q[0];
      default: cur_word = cmp_q[N_CMP-1];
    endcase
  end

  // shared holding register
  always_comb begin
    temp_en = hi_wr | lo_rd;
    temp_d  = hi_wr ? wdata : cur_word[WW-1:BUS_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       temp_q <= '0;
    else if (temp_en) temp_q <= temp_d;
  end

  // counter write request
  assign cnt_wr_o     = lo_wr & (wsel == W_CNT);
  assign cnt_wr_val_o = full_word;

  // capture register: hardware event wins over a bus write
  always_comb begin
    cap_evt = evt_i & ~ctrl_q.top_cap;
    cap_en  = cap_evt | (lo_wr & (wsel == W_CAP));
    cap_d   = cap_evt ? cnt_i : full_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cap_q <= '0;
    else if (cap_en) cap_q <= cap_d;
  end

  // compare channels
  for (genvar c = 0; c < N_CMP; c++) begin : g_cmp
    localparam word_e MY_WORD = word_e'(32'(W_CMPA) + c);
    logic          cmp_en;
    logic [WW-1:0] cmp_d;

    always_comb begin
      cmp_en     = lo_wr & (wsel == MY_WORD);
      cmp_d      = full_word;
      cmp_hit[c] = count_en & ~cnt_wr_o & (cnt_i == cmp_q[c]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cmp_q[c] <= '0;
      else if (cmp_en) cmp_q[c] <= cmp_d;
    end
  end

  // control and mask
  always_comb begin
    ctrl_en = wr_en & (addr == A_CTRL);
    mask_en = wr_en & (addr == A_MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_en) ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= wdata & FLG_VALID;
  end

  // flags: set beats clear
  always_comb begin
    set_vec           = '0;
    set_vec[FLG_CAP]  = cap_evt;
    set_vec[FLG_CMPA] = cmp_hit[0];
    set_vec[FLG_CMPB] = cmp_hit[N_CMP-1];
    set_vec[FLG_OVF]  = wrap_i;
    clr_vec  = (wr_en && addr == A_FLAG) ? (wdata & FLG_VALID) : '0;
    flags_en = (|set_vec) | (|clr_vec);
    flags_d  = (flags_q & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flags_q <= '0;
    else if (flags_en) flags_q <= flags_d;
  end

  // read mux
  always_comb begin
    rdata = '0;
    if (in_words) begin
      rdata = addr[0] ? temp_q : cur_word[BUS_W-1:0];
    end else begin
      case (addr)
        A_CTRL:  rdata = {{(BUS_W-CTRL_W){1'b0}}, ctrl_q};
        A_MASK:  rdata = mask_q;
        A_FLAG:  rdata = flags_q;
        default: rdata = '0;
      endcase
    end
  end

  assign irq_o   = global_ie & (|(mask_q & flags_q));
  assign cap_o   = cap_q;
  assign ctrl_o  = ctrl_q;
  assign mask_o  = mask_q;
  assign flags_o = flags_q;

endmodule

// File: rtl/icu_timer.sv
module icu_timer
  import icu_pkg::*;
#(
  parameter int BUS_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              count_en,
  input  logic              global_ie,
  input  logic              cap_pin,
  input  logic              cmp_in,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              irq
);

  localparam int CNT_W = 2 * BUS_W;

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0]       rst_pipe_q;
  logic             rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cap_q;
  logic [CNT_W-1:0] cnt_wr_val;
  logic             cnt_wr;
  logic             cap_evt;
  logic             wrap;
  ctrl_t            ctrl;
  logic [BUS_W-1:0] mask_q;
  logic [BUS_W-1:0] flags_q;

  icu_edge_sync #(
    .STAGES (SYNC_STAGES),
    .SRCS   (2)
  ) u_sync (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .raw_i  ({cmp_in, cap_pin}),
    .sel_i  (ctrl.src_cmp),
    .rise_i (ctrl.edge_rise),
    .evt_o  (cap_evt)
  );

  icu_counter #(
    .W (CNT_W)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .count_en (count_en),
    .top_mode (ctrl.top_cap),
    .top_val  (cap_q),
    .wr_en    (cnt_wr),
    .wr_val   (cnt_wr_val),
    .cnt_o    (cnt_q),
    .wrap_o   (wrap)
  );

  icu_regif #(
    .BUS_W (BUS_W),
    .N_CMP (2)
  ) u_regs (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .addr         (bus_addr),
    .wr_en        (bus_wr),
    .rd_en        (bus_rd),
    .wdata        (bus_wdata),
    .rdata        (bus_rdata),
    .count_en     (count_en),
    .global_ie    (global_ie),
    .cnt_i        (cnt_q),
    .evt_i        (cap_evt),
    .wrap_i       (wrap),
    .cnt_wr_o     (cnt_wr),
    .cnt_wr_val_o (cnt_wr_val),
    .cap_o        (cap_q),
    .ctrl_o       (ctrl),
    .mask_o       (mask_q),
    .flags_o      (flags_q),
    .irq_o        (irq)
  );

endmodule

// File: rtl/icu_timer_chk.sv
module icu_timer_chk #(
  parameter int W     = 16,
  parameter int BUS_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             count_en,
  input logic             global_ie,
  input logic             irq,
  input logic [W-1:0]     cnt,
  input logic [W-1:0]     cap,
  input logic [BUS_W-1:0] flags,
  input logic [BUS_W-1:0] mask,
  input logic             top_mode,
  input logic             cnt_wr,
  input logic             evt
);

  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] top_val;
  assign top_val = top_mode ? cap : '1;

  // R11: no request without the global enable
  p_irq_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !global_ie |-> !irq);

  // R11: a request needs an enabled, pending flag
  p_irq_source_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|(mask & flags)));

  // R2: counter steps by one below its wrap value
  p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && !cnt_wr && cnt != top_val) |=> cnt == ($past(cnt) + ONE));

  // R2: counter holds without enable or write
  p_cnt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!count_en && !cnt_wr) |=> $stable(cnt));

  // R3: wrap returns to zero and raises overflow
  p_cnt_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && !cnt_wr && cnt == top_val) |=> (cnt == '0 && flags[2]));

  // R4: a capture event stores the counter and raises the capture flag
  p_cap_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !top_mode) |=> (cap == $past(cnt) && flags[5]));

endmodule

bind icu_timer icu_timer_chk #(
  .W     (CNT_W),
  .BUS_W (BUS_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .count_en  (count_en),
  .global_ie (global_ie),
  .irq       (irq),
  .cnt       (cnt_q),
  .cap       (cap_q),
  .flags     (flags_q),
  .mask      (mask_q),
  .top_mode  (ctrl.top_cap),
  .cnt_wr    (cnt_wr),
  .evt       (cap_evt)
);

// File: tb/icu_timer_bench.sv
`timescale 1ns/1ps
module icu_timer_bench;

  logic       clk;
  logic       rst_n;
  logic       count_en;
  logic       global_ie;
  logic       cap_pin;
  logic       cmp_in;
  logic [3:0] bus_addr;
  logic       bus_wr;
  logic       bus_rd;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  icu_timer u_icu_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .count_en  (count_en),
    .global_ie (global_ie),
    .cap_pin   (cap_pin),
    .cmp_in    (cmp_in),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  localparam logic [3:0] AD_CNT  = 4'd0;
  localparam logic [3:0] AD_CAP  = 4'd2;
  localparam logic [3:0] AD_CMPA = 4'd4;
  localparam logic [3:0] AD_CMPB = 4'd6;
  localparam logic [3:0] AD_CTRL = 4'd8;
  localparam logic [3:0] AD_MASK = 4'd9;
  localparam logic [3:0] AD_FLAG = 4'd10;

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  // all bus tasks start and end just after a falling edge
  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wr16(input logic [3:0] lo, input logic [15:0] v);
    wr(lo + 4'd1, v[15:8]);
    wr(lo, v[7:0]);
  endtask

  task automatic rd16(input logic [3:0] lo, output logic [15:0] v);
    logic [7:0] l, h;
    rd(lo, l);
    rd(lo + 4'd1, h);
    v = {h, l};
  endtask

  task automatic tick(input int n);
    count_en = 1'b1;
    repeat (n) @(negedge clk);
    count_en = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [15:0] v; logic [7:0] b;
    rd16(AD_CNT, v);  check("R1 counter", v, 16'h0000);
    rd16(AD_CAP, v);  check("R1 capture", v, 16'h0000);
    rd16(AD_CMPA, v); check("R1 compare A", v, 16'h0000);
    rd16(AD_CMPB, v); check("R1 compare B", v, 16'h0000);
    rd(AD_CTRL, b);   check("R1 control", {8'h0, b}, 16'h0000);
    rd(AD_MASK, b);   check("R1 mask", {8'h0, b}, 16'h0000);
    rd(AD_FLAG, b);   check("R1 flags", {8'h0, b}, 16'h0000);
    check("R1 irq", {15'h0, irq}, 16'h0000);
  endtask

  task automatic t_count;
    logic [15:0] v; logic [7:0] b;
    wr16(AD_CNT, 16'h00FE);
    tick(3);
    rd16(AD_CNT, v); check("R2 three steps", v, 16'h0101);
    wait_cyc(4);
    rd16(AD_CNT, v); check("R2 hold without enable", v, 16'h0101);
    wr16(AD_CNT, 16'hFFFE);
    tick(1);
    rd(AD_FLAG, b);  check("R2 no overflow before wrap", {8'h0, b}, 16'h0000);
    tick(1);
    rd16(AD_CNT, v); check("R2 wrap to zero", v, 16'h0000);
    rd(AD_FLAG, b);  check("R2 overflow flag", {8'h0, b}, 16'h0004);
    wr(AD_FLAG, 8'h00);
    rd(AD_FLAG, b);  check("R10 zero write keeps flag", {8'h0, b}, 16'h0004);
    wr(AD_FLAG, 8'h04);
    rd(AD_FLAG, b);  check("R10 one clears flag", {8'h0, b}, 16'h0000);
  endtask

  task automatic t_atomic_read;
    logic [15:0] v; logic [7:0] b;
    wr16(AD_CNT, 16'h12FF);
    rd(AD_CNT, b);       check("R7 low byte", {8'h0, b}, 16'h00FF);
    tick(1);
    rd(AD_CNT + 4'd1, b); check("R7 high from snapshot", {8'h0, b}, 16'h0012);
    rd(AD_CNT, b);
    rd(AD_CAP + 4'd1, b); check("R7 holding register shared", {8'h0, b}, 16'h0013);
    rd16(AD_CNT, v);     check("R7 new value", v, 16'h1300);
  endtask

  task automatic t_atomic_write;
    logic [15:0] v;
    wr(AD_CMPA + 4'd1, 8'h34);
    rd16(AD_CMPA, v); check("R8 high write alone no commit", v, 16'h0000);
    wr(AD_CMPA + 4'd1, 8'h34);
    wr(AD_CMPA, 8'h56);
    rd16(AD_CMPA, v); check("R8 committed word", v, 16'h3456);
  endtask

  task automatic t_compare;
    logic [7:0] b;
    wr16(AD_CMPA, 16'h0010);
    wr16(AD_CMPB, 16'h0012);
    wr16(AD_CNT, 16'h000E);
    wr(AD_FLAG, 8'h3C);
    tick(2);
    rd(AD_FLAG, b); check("R9 no match yet", {8'h0, b}, 16'h0000);
    tick(1);
    rd(AD_FLAG, b); check("R9 compare A flag", {8'h0, b}, 16'h0010);
    tick(2);
    rd(AD_FLAG, b); check("R9 compare B flag", {8'h0, b}, 16'h0018);
    wr(AD_FLAG, 8'h18);
  endtask

  task automatic t_top;
    logic [15:0] v; logic [7:0] b;
    wr16(AD_CAP, 16'h0005);
    wr(AD_CTRL, 8'h04);
    wr16(AD_CNT, 16'h0000);
    wr(AD_FLAG, 8'h3C);
    tick(5);
    rd16(AD_CNT, v); check("R3 reaches top", v, 16'h0005);
    rd(AD_FLAG, b);  check("R3 no overflow at top", {15'h0, b[2]}, 16'h0000);
    tick(1);
    rd16(AD_CNT, v); check("R3 wrap after top", v, 16'h0000);
    rd(AD_FLAG, b);  check("R3 overflow on top wrap", {15'h0, b[2]}, 16'h0001);
    wr(AD_CTRL, 8'h05);
    wr(AD_FLAG, 8'h3C);
    cap_pin = 1'b1; wait_cyc(5);
    cap_pin = 1'b0; wait_cyc(5);
    rd16(AD_CAP, v); check("R3 capture ignored", v, 16'h0005);
    rd(AD_FLAG, b);  check("R3 capture flag stays clear", {15'h0, b[5]}, 16'h0000);
    wr(AD_CTRL, 8'h01);
  endtask

  task automatic t_capture;
    logic [15:0] v; logic [7:0] b;
    wr16(AD_CNT, 16'h0ABC);
    wr(AD_FLAG, 8'h3C);
    cap_pin = 1'b1;
    wait_cyc(2);
    rd(AD_CAP, b);   check("R4 not captured after two edges", {8'h0, b}, 16'h0005);
    rd16(AD_CAP, v); check("R4 captured after third edge", v, 16'h0ABC);
    rd(AD_FLAG, b);  check("R4 capture flag", {8'h0, b}, 16'h0020);
    wr16(AD_CNT, 16'h1111);
    cap_pin = 1'b0; wait_cyc(5);
    rd16(AD_CAP, v); check("R5 falling ignored in rising mode", v, 16'h0ABC);
    wr(AD_CTRL, 8'h00);
    cap_pin = 1'b1; wait_cyc(5);
    rd16(AD_CAP, v); check("R5 rising ignored in falling mode", v, 16'h0ABC);
    cap_pin = 1'b0; wait_cyc(5);
    rd16(AD_CAP, v); check("R5 falling captures", v, 16'h1111);
  endtask

  task automatic t_source;
    logic [15:0] v;
    wr(AD_CTRL, 8'h03);
    wr16(AD_CNT, 16'h2222);
    cap_pin = 1'b1; wait_cyc(5);
    rd16(AD_CAP, v); check("R6 pin ignored when comparator chosen", v, 16'h1111);
    cap_pin = 1'b0; wait_cyc(3);
    cmp_in = 1'b1; wait_cyc(5);
    rd16(AD_CAP, v); check("R6 comparator captures", v, 16'h2222);
    cmp_in = 1'b0; wait_cyc(3);
    wr(AD_CTRL, 8'h00);
    wait_cyc(3);
  endtask

  task automatic t_irq;
    logic [7:0] b;
    wr(AD_FLAG, 8'h3C);
    cap_pin = 1'b1; wait_cyc(3);
    cap_pin = 1'b0; wait_cyc(5);
    wr(AD_MASK, 8'hFF);
    rd(AD_MASK, b); check("R11 mask bits", {8'h0, b}, 16'h003C);
    global_ie = 1'b1; #1;
    check("R11 irq asserted", {15'h0, irq}, 16'h0001);
    wr(AD_MASK, 8'h10); #1;
    check("R11 masked flag no irq", {15'h0, irq}, 16'h0000);
    wr(AD_MASK, 8'h20);
    global_ie = 1'b0; #1;
    check("R11 global disable", {15'h0, irq}, 16'h0000);
  endtask

  task automatic t_set_wins;
    logic [7:0] b;
    wr16(AD_CNT, 16'hFFFF);
    wr(AD_FLAG, 8'h3C);
    rd(AD_FLAG, b); check("R10 cleared", {8'h0, b}, 16'h0000);
    count_en = 1'b1;
    bus_addr = AD_FLAG; bus_wdata = 8'h04; bus_wr = 1'b1;
    @(negedge clk);
    count_en = 1'b0; bus_wr = 1'b0;
    rd(AD_FLAG, b); check("R10 set wins over clear", {8'h0, b}, 16'h0004);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; count_en = 1'b0; global_ie = 1'b0;
    cap_pin = 1'b0; cmp_in = 1'b0;
    bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    wait_cyc(4);
    t_reset();
    t_count();
    t_atomic_read();
    t_atomic_write();
    t_compare();
    t_top();
    t_capture();
    t_source();
    t_irq();
    t_set_wins();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule